// File: doc/BRIEF.md
# Ray Node Prediction Table

This block is a small associative store that remembers where earlier rays found geometry. Each entry pairs a 15-bit spatial ray hash with a 27-bit tree-node offset. A traversal engine asks the table for a starting node before walking the tree from the root. It writes back the node that a successful walk found, so that later rays landing on the same hash can start deeper in the tree. A hit is only a hint; the requester still verifies it.

Requests arrive on two independent valid/ready channels, one for lookups and one for updates, and each channel has its own small queue. Every cycle the table takes at most one lookup and one update from the heads of these queues. The set index comes from xor-folding the hash. All four ways of the set are compared at once. A lookup result is registered, so it appears one cycle after the request leaves its queue. A clear input empties the table at frame boundaries.

Top module: `ray_pred_table`

## Requirements
- R1: After reset the table holds no valid entry, both queues are empty with their ready outputs high, and the result valid output is low.
- R2: The set index is hash[7:0] xor {1'b0, hash[14:8]}, and all 15 hash bits form the tag, so different hashes that fold to one set compete for that set's 4 ways.
- R3: A lookup compares its tag with every way of its set and returns hit=1 with the stored node, or hit=0 on a miss, together with the request hash. The result is valid exactly one cycle after the request leaves the queue, which is two cycles after it is accepted into an empty queue.
- R4: An update whose tag is already present in the set replaces that entry's node and does not occupy a second way.
- R5: An update with a new tag fills the lowest-numbered invalid way of the set. If all 4 ways are valid, it replaces the least recently used way.
- R6: A lookup hit counts as a use of that way for recency, just as an update does.
- R7: When a lookup and an update to the same set leave their queues in the same cycle, the lookup returns the contents from before the update.
- R8: Clear invalidates every entry at the next clock edge. While clear is high no request leaves either queue and no result is produced, and no queued request is lost.
- R9: Each queue holds 4 requests, keeps them in arrival order, and drives its ready output low while full.
- R10: One lookup and one update can complete in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Invalidate all entries; holds both queues |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup queue can accept |
| lk_hash_i | input | 15 | Lookup ray hash |
| up_valid_i | input | 1 | Update request valid |
| up_ready_o | output | 1 | Update queue can accept |
| up_hash_i | input | 15 | Update ray hash |
| up_node_i | input | 27 | Node offset to store |
| res_valid_o | output | 1 | Lookup result valid (one cycle) |
| res_hit_o | output | 1 | Lookup found a matching entry |
| res_node_o | output | 27 | Predicted node offset (zero on miss) |
| res_hash_o | output | 15 | Hash of the lookup this result answers |

## Verification
The bench fills one set with five hashes whose set index exists only after folding. A table that indexed on the low bits alone would leave the evicted hash present. It rewrites an existing tag and then checks that the other three entries survive, which a design that allocates a fresh way would break. It arranges recency so that the victim differs depending on whether lookups refresh LRU state; the wrong choice evicts an entry that was just read. It also issues a lookup and an update to one set in the same cycle, where a forwarding design would return the new node. Finally it holds clear while filling the lookup queue: a design that popped during clear would emit results early, and one that dropped requests would return fewer than four answers or return them out of order.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    // Default geometry of the prediction table.
    parameter int DEF_HASH_W = 15;
    parameter int DEF_NODE_W = 27;
    parameter int DEF_WAYS   = 4;
    parameter int DEF_SETS   = 256;
    parameter int DEF_QDEPTH = 4;
endpackage

// File: rtl/rpt_fifo.sv
// Request queue with valid/ready on the write side and a pop strobe on the
// read side. Assumes DEPTH >= 2. Head data is combinational from storage.
module rpt_fifo #(
    parameter int W     = 15,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_pop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push, pop;

    assign in_ready  = (count != CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign push      = in_valid && in_ready;
    assign pop       = out_pop && out_valid;
    assign out_data  = mem[rd_ptr];

    // Store an accepted request at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R9: occupancy never passes the depth
    a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R9: a full queue with no pop stays full and takes nothing
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_pop) |=> (count == $past(count)));
endmodule

// File: rtl/rpt_fold.sv
// Xor-folds a hash into a set index: the hash is zero-extended to a whole
// number of IDX_W-bit pieces and the pieces are xor-ed together.
module rpt_fold #(
    parameter int HASH_W = 15,
    parameter int IDX_W  = 8
) (
    input  logic [HASH_W-1:0] hash_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int PIECES = (HASH_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = PIECES * IDX_W;

    logic [PAD_W-1:0]           padded;
    logic [PIECES:0][IDX_W-1:0] acc;

    assign padded = PAD_W'(hash_i);
    assign acc[0] = '0;

    for (genvar p = 0; p < PIECES; p++) begin : g_piece
        assign acc[p+1] = acc[p] ^ padded[p*IDX_W +: IDX_W];
    end

    assign idx_o = acc[PIECES];
endmodule

// File: rtl/rpt_store.sv
// Set-associative entry store with per-way recency ages. One lookup read and
// one update write per cycle; lookup data is registered (1-cycle latency).
// Assumes SETS and WAYS are powers of two. Within a set the ages always form
// a permutation of 0..WAYS-1; age WAYS-1 marks the least recently used way.
module rpt_store #(
    parameter int HASH_W = 15,
    parameter int NODE_W = 27,
    parameter int WAYS   = 4,
    parameter int SETS   = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     lk_en_i,
    input  logic [$clog2(SETS)-1:0]  lk_idx_i,
    input  logic [HASH_W-1:0]        lk_tag_i,
    input  logic                     up_en_i,
    input  logic [$clog2(SETS)-1:0]  up_idx_i,
    input  logic [HASH_W-1:0]        up_tag_i,
    input  logic [NODE_W-1:0]        up_node_i,
    output logic                     rd_valid_o,
    output logic                     rd_hit_o,
    output logic [NODE_W-1:0]        rd_node_o,
    output logic [HASH_W-1:0]        rd_tag_o
);
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAYS-1:0][WAY_W-1:0] age_vec_t;

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [HASH_W-1:0]         tag_q  [SETS][WAYS];
    logic [NODE_W-1:0]         node_q [SETS][WAYS];
    age_vec_t                  age_q  [SETS];

    logic [WAYS-1:0]   lk_match, up_match, up_free;
    logic              lk_any, up_any;
    logic [WAY_W-1:0]  lk_way, up_way;
    logic [NODE_W-1:0] lk_node;
    age_vec_t          up_pre;

    // Mark one way most recent; ways younger than it age by one.
    function automatic age_vec_t touch(input age_vec_t a, input logic [WAY_W-1:0] way);
        age_vec_t r;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way)   r[w] = '0;
            else if (a[w] < a[way]) r[w] = a[w] + 1'b1;
            else                    r[w] = a[w];
        end
        return r;
    endfunction

    // Lowest-numbered set bit.
    function automatic logic [WAY_W-1:0] first_one(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
        return r;
    endfunction

    // Way holding the oldest age.
    function automatic logic [WAY_W-1:0] oldest(input age_vec_t a);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int w = 0; w < WAYS; w++) if (a[w] == WAY_W'(WAYS - 1)) r = WAY_W'(w);
        return r;
    endfunction

    // Lookup side: compare the tag against every way of the set.
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            lk_match[w] = vld_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
        lk_any  = |lk_match;
        lk_way  = first_one(lk_match);
        lk_node = lk_any ? node_q[lk_idx_i][lk_way] : '0;
    end

    // Update side: reuse a matching way, else a free way, else the LRU way.
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            up_match[w] = vld_q[up_idx_i][w] && (tag_q[up_idx_i][w] == up_tag_i);
        up_any  = |up_match;
        up_free = ~vld_q[up_idx_i];
        up_pre  = age_q[up_idx_i];
        if (lk_en_i && lk_any && (lk_idx_i == up_idx_i))
            up_pre = touch(up_pre, lk_way);
        if (up_any)        up_way = first_one(up_match);
        else if (|up_free) up_way = first_one(up_free);
        else               up_way = oldest(up_pre);
    end

    // Write tag and node of the chosen way.
    always_ff @(posedge clk) begin
        if (up_en_i && !clear_i) begin
            tag_q[up_idx_i][up_way]  <= up_tag_i;
            node_q[up_idx_i][up_way] <= up_node_i;
        end
    end

    // Valid bits and recency ages; the update's age write follows the lookup's.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (clear_i) begin
            vld_q <= '0;
        end else begin
            if (lk_en_i && lk_any)
                age_q[lk_idx_i] <= touch(age_q[lk_idx_i], lk_way);
            if (up_en_i) begin
                age_q[up_idx_i]         <= touch(up_pre, up_way);
                vld_q[up_idx_i][up_way] <= 1'b1;
            end
        end
    end

    // Register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_hit_o   <= 1'b0;
            rd_node_o  <= '0;
            rd_tag_o   <= '0;
        end else begin
            rd_valid_o <= lk_en_i;
            rd_hit_o   <= lk_en_i && lk_any;
            rd_node_o  <= lk_node;
            rd_tag_o   <= lk_tag_i;
        end
    end

    // R4: a tag is held by at most one way of its set
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(up_match));
    // R5: a new tag in a set with a free way adds exactly one valid way
    a_r5_fill_free: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en_i && !clear_i && !up_any && (|up_free))
        |=> ($countones(vld_q[$past(up_idx_i)]) == $countones($past(vld_q[up_idx_i])) + 1));
    // R8: clear leaves no valid entry
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (vld_q == '0));
endmodule

// File: rtl/ray_pred_table.sv
// Ray node prediction table top: two request queues, hash folding for each
// request path, and the set-associative store. Clear holds both queues so
// no request is consumed while the table is being emptied.
module ray_pred_table
    import rpt_pkg::*;
#(
    parameter int HASH_W = DEF_HASH_W,
    parameter int NODE_W = DEF_NODE_W,
    parameter int WAYS   = DEF_WAYS,
    parameter int SETS   = DEF_SETS,
    parameter int QDEPTH = DEF_QDEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              lk_valid_i,
    output logic              lk_ready_o,
    input  logic [HASH_W-1:0] lk_hash_i,
    input  logic              up_valid_i,
    output logic              up_ready_o,
    input  logic [HASH_W-1:0] up_hash_i,
    input  logic [NODE_W-1:0] up_node_i,
    output logic              res_valid_o,
    output logic              res_hit_o,
    output logic [NODE_W-1:0] res_node_o,
    output logic [HASH_W-1:0] res_hash_o
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int UPQ_W  = HASH_W + NODE_W;

    logic              lk_head_v, up_head_v, lk_pop, up_pop;
    logic [HASH_W-1:0] lk_head;
    logic [UPQ_W-1:0]  up_head;
    logic [IDX_W-1:0]  lk_idx, up_idx;

    assign lk_pop = lk_head_v && !clear_i;
    assign up_pop = up_head_v && !clear_i;

    rpt_fifo #(.W(HASH_W), .DEPTH(QDEPTH)) u_lk_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(lk_valid_i), .in_ready(lk_ready_o), .in_data(lk_hash_i),
        .out_valid(lk_head_v), .out_data(lk_head), .out_pop(lk_pop));

    rpt_fifo #(.W(UPQ_W), .DEPTH(QDEPTH)) u_up_q (
        .clk(clk), .rst_n(rst_n),
        .in_valid(up_valid_i), .in_ready(up_ready_o), .in_data({up_hash_i, up_node_i}),
        .out_valid(up_head_v), .out_data(up_head), .out_pop(up_pop));

    rpt_fold #(.HASH_W(HASH_W), .IDX_W(IDX_W)) u_lk_fold (
        .hash_i(lk_head), .idx_o(lk_idx));

    rpt_fold #(.HASH_W(HASH_W), .IDX_W(IDX_W)) u_up_fold (
        .hash_i(up_head[UPQ_W-1 -: HASH_W]), .idx_o(up_idx));

    rpt_store #(.HASH_W(HASH_W), .NODE_W(NODE_W), .WAYS(WAYS), .SETS(SETS)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .lk_en_i(lk_pop), .lk_idx_i(lk_idx), .lk_tag_i(lk_head),
        .up_en_i(up_pop), .up_idx_i(up_idx),
        .up_tag_i(up_head[UPQ_W-1 -: HASH_W]), .up_node_i(up_head[NODE_W-1:0]),
        .rd_valid_o(res_valid_o), .rd_hit_o(res_hit_o),
        .rd_node_o(res_node_o), .rd_tag_o(res_hash_o));

    // R3: every lookup leaving the queue yields a result next cycle
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pop |=> res_valid_o);
    // R8: no result follows a cycle with clear high
    a_r8_clear_stall: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !res_valid_o);
    // R3: a miss carries a zero node
    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_hit_o) |-> (res_node_o == '0));
endmodule

// File: tb/sim_ray_pred_table.sv
`timescale 1ns/1ps
module sim_ray_pred_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        lk_valid_i = 1'b0, up_valid_i = 1'b0;
    logic [14:0] lk_hash_i = '0, up_hash_i = '0;
    logic [26:0] up_node_i = '0;
    logic        lk_ready_o, up_ready_o, res_valid_o, res_hit_o;
    logic [26:0] res_node_o;
    logic [14:0] res_hash_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    ray_pred_table u0 (.*);

    // {op(1=update), hash(15), node(27), expected hit(1)}
    // Hashes 0005,0104,0207,0306,0401 all fold to set 5 (R2).
    localparam int NV = 19;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 15'h0005, 27'h0000000, 1'b0}, // R1 empty table misses
        {1'b1, 15'h0005, 27'h0000111, 1'b0},
        {1'b0, 15'h0005, 27'h0000111, 1'b1}, // R3 hit
        {1'b1, 15'h0104, 27'h0000222, 1'b0}, // R5 free ways
        {1'b1, 15'h0207, 27'h0000333, 1'b0},
        {1'b1, 15'h0306, 27'h0000444, 1'b0},
        {1'b0, 15'h0104, 27'h0000222, 1'b1},
        {1'b1, 15'h0005, 27'h0000155, 1'b0}, // R4 rewrite in place
        {1'b0, 15'h0005, 27'h0000155, 1'b1}, // R4
        {1'b1, 15'h0401, 27'h0000555, 1'b0}, // R5 evicts LRU 0207
        {1'b0, 15'h0207, 27'h0000000, 1'b0}, // R2 R5 evicted
        {1'b0, 15'h0306, 27'h0000444, 1'b1},
        {1'b0, 15'h0104, 27'h0000222, 1'b1},
        {1'b0, 15'h0401, 27'h0000555, 1'b1},
        {1'b0, 15'h0005, 27'h0000155, 1'b1}, // R4 no second way used
        {1'b1, 15'h0207, 27'h0000666, 1'b0}, // R6 LRU is 0306 via lookups
        {1'b0, 15'h0104, 27'h0000222, 1'b1}, // R6 kept by lookup refresh
        {1'b0, 15'h0306, 27'h0000000, 1'b0}, // R6 evicted
        {1'b0, 15'h0105, 27'h0000000, 1'b0}  // R2 other set, no alias
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [14:0] h, input logic [26:0] n);
        @(negedge clk);
        up_valid_i = 1'b1; up_hash_i = h; up_node_i = n;
        @(negedge clk);
        up_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_lookup(input string req, input logic [14:0] h,
                             input logic exp_hit, input logic [26:0] exp_node);
        @(negedge clk);
        lk_valid_i = 1'b1; lk_hash_i = h;
        @(negedge clk);
        lk_valid_i = 1'b0;
        chk({req, " no early result"}, 32'(res_valid_o), 32'd0);
        @(negedge clk);
        chk({req, " valid"}, 32'(res_valid_o), 32'd1);
        chk({req, " hit"}, 32'(res_hit_o), 32'(exp_hit));
        chk({req, " node"}, 32'(res_node_o), exp_hit ? 32'(exp_node) : 32'd0);
        chk({req, " hash"}, 32'(res_hash_o), 32'(h));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lk_ready", 32'(lk_ready_o), 32'd1);
        chk("R1 up_ready", 32'(up_ready_o), 32'd1);
        chk("R1 res_valid", 32'(res_valid_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][43]) do_update(VEC[i][42:28], VEC[i][27:1]);
            else do_lookup($sformatf("R3 vec%0d", i), VEC[i][42:28], VEC[i][0], VEC[i][27:1]);
        end

        // R7 R10: lookup and update to one set leave their queues together
        @(negedge clk);
        lk_valid_i = 1'b1; lk_hash_i = 15'h0207;
        up_valid_i = 1'b1; up_hash_i = 15'h0207; up_node_i = 27'h777;
        @(negedge clk);
        lk_valid_i = 1'b0; up_valid_i = 1'b0;
        @(negedge clk);
        chk("R7 same-cycle valid", 32'(res_valid_o), 32'd1);
        chk("R7 sees old node", 32'(res_node_o), 32'h666);
        do_lookup("R10 update landed", 15'h0207, 1'b1, 27'h777);

        // R8 R9: hold clear, fill lookup queue, check stall, order, and emptiness
        @(negedge clk);
        clear_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            lk_valid_i = 1'b1;
            lk_hash_i = (k == 0) ? 15'h0005 : (k == 1) ? 15'h0104 :
                        (k == 2) ? 15'h0401 : 15'h0207;
            @(negedge clk);
            chk("R8 no result during clear", 32'(res_valid_o), 32'd0);
        end
        chk("R9 full queue not ready", 32'(lk_ready_o), 32'd0);
        lk_valid_i = 1'b0;
        clear_i = 1'b0;
        begin
            int got;
            got = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (res_valid_o) begin
                    chk("R8 cleared entry misses", 32'(res_hit_o), 32'd0);
                    chk("R9 order", 32'(res_hash_o),
                        (got == 0) ? 32'h0005 : (got == 1) ? 32'h0104 :
                        (got == 2) ? 32'h0401 : 32'h0207);
                    got++;
                end
            end
            chk("R8 no request lost", 32'(got), 32'd4);
        end
        chk("R9 ready again", 32'(lk_ready_o), 32'd1);

        // R5 after clear the set refills from way 0 without eviction trouble
        do_update(15'h0306, 27'h888);
        do_lookup("R5 refill after clear", 15'h0306, 1'b1, 27'h888);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule